// File: doc/BRIEF.md
# Serial-Priority Interrupt Acknowledge Chain

This block gathers a row of peripheral interrupt slots behind one shared, active-low request line to a processor. Each slot keeps its own pending flag. The flag is set by a request pulse from its peripheral and stays set until that peripheral reports that its service has finished. Any slot with a pending flag pulls the shared line low, so the line acts as a wired OR of all the slots.

When the processor answers the request, it raises a single acknowledge. The acknowledge enters slot 0 and travels toward the last slot. The first pending slot it reaches takes it and puts its own identification byte on the shared data bus, which the processor reads to find its handler. A slot that is not pending passes the acknowledge on. If no slot takes it, the acknowledge leaves the end of the chain and the bus reads all ones.

The slot that wins an acknowledge keeps it for as long as the acknowledge stays high. A later request from a slot nearer the head does not take it away. Priority therefore comes only from where a slot sits along the chain.

Top module: `irq_chain`

## Requirements
- R1: During reset and after it, with no requests: `irq_n` is 1, `data_bus` is all ones and `ack_tail` is 0 while `ack_in` is low.
- R2: A pulse on `req_set[k]` marks slot k pending from the next clock edge. `irq_n` is low exactly when at least one slot is pending.
- R3: A pending slot stays pending, and `irq_n` stays low, until its own service-done pulse is accepted. Idle cycles and acknowledges do not clear it.
- R4: The acknowledge enters slot 0 first. In the same cycle `ack_in` rises, the pending slot with the lowest index claims it, and `data_bus` shows that slot's identification, `ID_BASE + k*ID_STEP` (defaults 0x30 and 0x05).
- R5: If no slot is pending when the acknowledge arrives, it passes the end of the chain: `ack_tail` is 1 and `data_bus` is all ones.
- R6: A slot that claims the acknowledge does not forward it. `ack_tail` is 0 and `data_bus` carries exactly one slot's identification.
- R7: The result decided in the first acknowledge cycle is held unchanged until `ack_in` goes low. This holds even if a slot nearer the head raises a new request meanwhile.
- R8: `done[k]` clears slot k only while slot k holds the acknowledge. A done pulse to any other slot is ignored. A request and an accepted done in the same cycle leave the slot pending.
- R9: While `ack_in` is low, `data_bus` is all ones and `ack_tail` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_set | input | N | Per-slot request pulse, sets the pending flag |
| done | input | N | Per-slot service-done pulse |
| ack_in | input | 1 | Acknowledge from the processor, active high, enters slot 0 |
| irq_n | output | 1 | Shared active-low request line |
| data_bus | output | IDW | Identification of the claiming slot, all ones if none |
| ack_tail | output | 1 | Acknowledge leaving the last slot unclaimed |

## Verification
Every internal state of this block shows up at a port within one cycle. A lost or stuck pending flag changes `irq_n`, or changes which identification appears at the next acknowledge. A claim register that does not hold shows up as `data_bus` changing in the middle of an acknowledge. The random stimulus therefore compares all three outputs every cycle, so a divergence is reported in the cycle it appears. The directed cases target late requests from higher-priority slots and done pulses sent to the wrong slot.

// File: rtl/irq_chain.sv
module irq_chain #(
  parameter int N = 6,
  parameter int IDW = 8,
  parameter logic [IDW-1:0] ID_BASE = 8'h30,
  parameter logic [IDW-1:0] ID_STEP = 8'h05
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req_set,
  input  logic [N-1:0]   done,
  input  logic           ack_in,
  output logic           irq_n,
  output logic [IDW-1:0] data_bus,
  output logic           ack_tail
);

  logic [N-1:0] pending, held, grant, owner;
  logic         held_v;

  always_comb begin
    logic run;
    run = ack_in;
    for (int k = 0; k < N; k++) begin
      grant[k] = run & pending[k];
      run      = run & ~pending[k];
    end
  end

  assign owner    = !ack_in ? '0 : (held_v ? held : grant);
  assign ack_tail = ack_in & ~|owner;
  assign irq_n    = ~|pending;

  always_comb begin
    data_bus = '1;
    for (int k = 0; k < N; k++)
      if (owner[k]) data_bus = IDW'(ID_BASE + ID_STEP * k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      held    <= '0;
      held_v  <= 1'b0;
    end else begin
      pending <= (pending & ~(done & owner)) | req_set;
      held_v  <= ack_in;
      held    <= owner;
    end
  end

endmodule

module irq_chain_chk #(
  parameter int N = 6,
  parameter int IDW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   req_set,
  input logic [N-1:0]   done,
  input logic           ack_in,
  input logic           irq_n,
  input logic [IDW-1:0] data_bus,
  input logic           ack_tail
);

  AST_SET_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (|req_set) |=> !irq_n); // R2
  AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!irq_n && !(|done)) |=> !irq_n); // R3
  AST_TAIL_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) ack_tail |-> (data_bus == '1)); // R5
  AST_ID_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n) (data_bus != '1) |-> (ack_in && !ack_tail)); // R6
  AST_CLAIM_STABLE: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && ack_in && $past(ack_in)) |-> ($stable(data_bus) && $stable(ack_tail))); // R7
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n) !ack_in |-> (data_bus == '1 && !ack_tail)); // R9

endmodule

bind irq_chain irq_chain_chk #(.N(N), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_set(req_set), .done(done), .ack_in(ack_in),
  .irq_n(irq_n), .data_bus(data_bus), .ack_tail(ack_tail)
);

// File: tb/irq_chain_bench.sv
`timescale 1ns/1ps
module irq_chain_bench;
  localparam int N = 6;
  localparam int IDW = 8;

  logic clk = 0, rst_n = 0, ack_in = 0;
  logic [N-1:0] req_set = '0, done = '0;
  logic irq_n, ack_tail;
  logic [IDW-1:0] data_bus;

  int tests = 0, fails = 0;
  logic [N-1:0] m_pend = '0, m_held = '0;
  logic m_held_v = 0;

  always #2 clk = ~clk;

  irq_chain #(.N(N), .IDW(IDW)) u_irq_chain (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .done(done), .ack_in(ack_in),
    .irq_n(irq_n), .data_bus(data_bus), .ack_tail(ack_tail)
  );

  function automatic logic [IDW-1:0] id_of(int k);
    return IDW'(8'h30 + 8'h05 * k);
  endfunction

  function automatic logic [N-1:0] exp_owner(logic ak);
    logic [N-1:0] g;
    g = '0;
    if (!ak) return '0;
    if (m_held_v) return m_held;
    for (int k = 0; k < N; k++)
      if (m_pend[k]) begin g[k] = 1'b1; return g; end
    return g;
  endfunction

  function automatic logic [IDW-1:0] exp_bus(logic [N-1:0] o);
    for (int k = 0; k < N; k++) if (o[k]) return id_of(k);
    return '1;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic [N-1:0] rs, logic [N-1:0] dn, logic ak, string tag);
    logic [N-1:0] o;
    @(negedge clk);
    req_set = rs; done = dn; ack_in = ak;
    #1;
    o = exp_owner(ak);
    check("R2 irq_n", irq_n, m_pend == '0);
    check({tag, " data_bus"}, data_bus, exp_bus(o));
    check({tag, " ack_tail"}, ack_tail, ak && o == '0);
    @(posedge clk);
    m_pend   = (m_pend & ~(dn & o)) | rs;
    m_held_v = ak;
    m_held   = o;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic ak;
    logic [N-1:0] rs, dn;
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    #1;
    check("R1 irq_n in reset", irq_n, 1);
    check("R1 data_bus in reset", data_bus, 8'hFF);
    check("R1 ack_tail in reset", ack_tail, 0);
    @(negedge clk); rst_n = 1;
    step('0, '0, 0, "R1 R9");

    // R5: acknowledge with nothing pending falls off the end
    step('0, '0, 1, "R5");
    check("R5 tail", ack_tail, 1);
    step('0, '0, 0, "R9");

    // R4/R7: slot 3 claims, then slot 0 requests mid-acknowledge
    step(6'b001000, '0, 0, "R2");
    step('0, '0, 1, "R4");
    check("R4 id slot3", data_bus, id_of(3));
    step(6'b000001, '0, 1, "R7");
    step('0, '0, 1, "R7");
    check("R7 claim held", data_bus, id_of(3));
    // R8: done to slot 1 ignored, done to slot 3 accepted while held
    step('0, 6'b000010, 1, "R8");
    step('0, 6'b001000, 1, "R8");
    step('0, '0, 0, "R9");
    step('0, '0, 1, "R4 R6");
    check("R4 slot0 wins", data_bus, id_of(0));
    check("R6 no forward", ack_tail, 0);
    // R8: request and done together keep slot 0 pending
    step(6'b000001, 6'b000001, 1, "R8");
    step('0, '0, 0, "R3");
    check("R3 still pending", irq_n, 0);
    step('0, '0, 1, "R3");
    check("R3 slot0 again", data_bus, id_of(0));
    step('0, 6'b000001, 1, "R8");
    step('0, '0, 0, "R9");
    check("R8 cleared", irq_n, 1);

    ak = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 4) == 0) ak = ~ak;
      rs = ($urandom_range(0, 5) == 0) ? N'(1 << $urandom_range(0, N-1)) : '0;
      dn = ($urandom_range(0, 3) == 0) ? (($urandom_range(0, 1) == 1) ? exp_owner(ak)
                                          : N'(1 << $urandom_range(0, N-1))) : '0;
      step(rs, dn, ak, "R4 R5 R6 R7 R8 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule